// File: doc/BRIEF.md
# ATA Task-File I/O Register Decoder

This block sits between a PC Card style I/O bus and the controller of a storage device. It compares address lines A9..A0 against one of two address blocks, chosen by a configuration input. It then reads the two active-low card-enable strobes to decide how the access is laid out on the 16-bit data bus. From that it reads or writes one of the ATA task-file registers. The parameter registers are held inside the block. Status, alternate status, error and drive address come from the command engine as read-only inputs. Command-register writes leave the block as a one-cycle command strobe. Device-control writes are held in a register that drives an output.

Data-register traffic goes to a word-wide data port. The port presents its next word ahead of time (show-ahead) and takes a one-cycle read or write strobe for each word moved. A 16-bit access moves a whole word at once. Byte-wide accesses go through a pairing toggle, which sends one word to the port only after the odd byte arrives. The data-register offset is shared with the error/feature byte register. Which of the two an access reaches depends on the card-enable pattern.

An access is any clock cycle in which exactly one of the I/O read and I/O write strobes is low. All outputs are combinational from the inputs and the state in that same cycle. Register writes take effect at the clock edge that ends the cycle.

Top module: `ata_tf_decoder`

## Requirements
- R1: With `sec_sel`=0 the task-file block is 1F0h..1F7h and the control block is 3F6h..3F7h. With `sec_sel`=1 the blocks are 170h..177h and 376h..377h. An access to any other address leaves `doe` low and `dout` zero, raises no strobe and changes no register.
- R2: The task-file offsets are: 1 error (read) / feature (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 card/head. All of these reset to zero and read back as written, except that reads of offset 1 return `error_in`. `param_out` is {card/head, cylinder high, cylinder low, sector number, sector count, feature}, with feature in bits 7..0.
- R3: With both card enables low, task-file offsets 0 and 1 form a 16-bit data access. A read drives `dp_rdata` on `dout` and pulses `dp_rd`. A write pulses `dp_wr` with `dp_wdata`=`din`. Either access clears the byte-pair toggle.
- R4: With `ce1_n` low, `ce2_n` high and offset 0, successive byte accesses alternate between the even byte and the odd byte on `dout[7:0]`/`din[7:0]`, starting with the even byte after reset. An even read returns `dp_rdata[7:0]` without a strobe. An odd read returns `dp_rdata[15:8]` and pulses `dp_rd`. An odd write pulses `dp_wr` with {odd byte, stored even byte}.
- R5: With `ce1_n` high, `ce2_n` low and offset 0 or 1, a read returns `error_in` on `dout[15:8]` and a write loads feature from `din[15:8]`. The byte-pair toggle is unchanged.
- R6: A write to task-file offset 7 pulses `cmd_valid` for one cycle with the written byte on `cmd_byte` and clears the byte-pair toggle. A read of offset 7 returns `status_in` and pulses `int_ack`.
- R7: Control offset 6 reads `altstat_in` without `int_ack`, and writes load `devctl_out`. Control offset 7 reads `drvaddr_in`. A write to control offset 7 changes nothing.
- R8: Offsets 0..5 of the control address group (3F0h..3F5h or 370h..375h) are undecoded. Reads leave `doe` low and writes change nothing.
- R9: With both card enables low, a task-file or control offset other than 0/1 reaches the even register of the pair (offset with bit 0 cleared) on bits 7..0 and the odd register (bit 0 set) on bits 15..8.
- R10: `doe` is high only during a decoded read. A byte lane that the access does not select reads as zero. A cycle with both I/O strobes low, or with both card enables high, is not an access.
- R11: Strobes and read data appear in the same cycle as the access. A register write is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_sel | input | 1 | 0 selects the primary address block, 1 the secondary |
| addr | input | 10 | I/O address A9..A0 |
| ce1_n | input | 1 | Card enable for the even/low byte, active low |
| ce2_n | input | 1 | Card enable for the odd/high byte, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data to the bus |
| doe | output | 1 | Read data drive enable |
| status_in | input | 8 | Device status byte |
| altstat_in | input | 8 | Alternate status byte |
| error_in | input | 8 | Error byte |
| drvaddr_in | input | 8 | Drive address byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command code written |
| int_ack | output | 1 | One-cycle pulse on a status read |
| devctl_out | output | 8 | Device control register |
| param_out | output | 48 | Parameter registers, packed as in R2 |
| dp_rdata | input | 16 | Show-ahead word from the data port |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wr | output | 1 | Data-port write strobe |
| dp_wdata | output | 16 | Data-port write word |

## Verification
The hardest state to reach from the ports is a byte pair left half-done and then interrupted. The interruption can be a 16-bit data access or a command write. It can also be an odd-lane error/feature access, which must leave the pair alone. The stimulus opens pairs on purpose, then injects each kind of interruption and finishes with the next byte access, so that the port strobe shows which half the toggle points at. Long random runs then mix all four card-enable patterns across both address blocks and the undecoded control offsets. A behavioural model predicts every output and register on each clock.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int BYTE_W   = 8;
  localparam int RD_SLOTS = 9;

  // Register selected on one byte lane
  typedef enum logic [3:0] {
    RS_NONE, RS_DATA, RS_ERRFEAT, RS_SECCNT, RS_SECNUM, RS_CYLLO,
    RS_CYLHI, RS_HEAD, RS_STATCMD, RS_ALTCTL, RS_DRVADDR
  } reg_sel_e;

  // Card-enable pattern
  typedef enum logic [1:0] {CE_NONE, CE_WORD, CE_EVEN, CE_ODD} ce_mode_e;

  function automatic ce_mode_e ce_decode(input logic ce1_n, input logic ce2_n);
    case ({ce2_n, ce1_n})
      2'b00:   return CE_WORD;
      2'b10:   return CE_EVEN;
      2'b01:   return CE_ODD;
      default: return CE_NONE;
    endcase
  endfunction

  function automatic reg_sel_e tf_sel(input logic [2:0] off);
    case (off)
      3'd1:    return RS_ERRFEAT;
      3'd2:    return RS_SECCNT;
      3'd3:    return RS_SECNUM;
      3'd4:    return RS_CYLLO;
      3'd5:    return RS_CYLHI;
      3'd6:    return RS_HEAD;
      3'd7:    return RS_STATCMD;
      default: return RS_NONE;
    endcase
  endfunction

  function automatic reg_sel_e ctl_sel(input logic [2:0] off);
    case (off)
      3'd6:    return RS_ALTCTL;
      3'd7:    return RS_DRVADDR;
      default: return RS_NONE;
    endcase
  endfunction

  function automatic logic sel_readable(input reg_sel_e s);
    return (s != RS_NONE) && (s != RS_DATA);
  endfunction

  // Slot of a readable register in the read bank
  function automatic int unsigned rd_slot(input reg_sel_e s);
    return int'(s) - int'(RS_ERRFEAT);
  endfunction

  function automatic logic [BYTE_W-1:0] bank_pick(
      input reg_sel_e s, input logic [RD_SLOTS-1:0][BYTE_W-1:0] bank);
    if (!sel_readable(s)) return '0;
    return bank[rd_slot(s)];
  endfunction

  // Storable register in regfile slot g
  function automatic reg_sel_e store_sel(input int g);
    case (g)
      0:       return RS_ERRFEAT;
      1:       return RS_SECCNT;
      2:       return RS_SECNUM;
      3:       return RS_CYLLO;
      4:       return RS_CYLHI;
      5:       return RS_HEAD;
      6:       return RS_ALTCTL;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ata_tf_addr_dec.sv
module ata_tf_addr_dec #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 3,
  parameter logic [ADDR_W-1:0] PRI_TF  = 10'h1F0,
  parameter logic [ADDR_W-1:0] PRI_CTL = 10'h3F0,
  parameter logic [ADDR_W-1:0] SEC_TF  = 10'h170,
  parameter logic [ADDR_W-1:0] SEC_CTL = 10'h370
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_tf,
  output logic              in_ctl,
  output logic [OFF_W-1:0]  off
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic [HI_W-1:0] tf_hi, ctl_hi, a_hi;

  assign a_hi   = addr[ADDR_W-1:OFF_W];
  assign tf_hi  = sec_sel ? SEC_TF[ADDR_W-1:OFF_W]  : PRI_TF[ADDR_W-1:OFF_W];
  assign ctl_hi = sec_sel ? SEC_CTL[ADDR_W-1:OFF_W] : PRI_CTL[ADDR_W-1:OFF_W];
  assign off    = addr[OFF_W-1:0];
  assign in_tf  = (a_hi == tf_hi);
  // only the top two offsets of the control group are decoded
  assign in_ctl = (a_hi == ctl_hi) && (addr[OFF_W-1:1] == '1);

  AST_REGION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_tf && in_ctl)); // R1

endmodule

// File: rtl/ata_tf_lane_map.sv
module ata_tf_lane_map
  import ata_tf_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  ce_mode_e         ce_mode,
  input  logic             in_tf,
  input  logic             in_ctl,
  input  logic [OFF_W-1:0] off,
  output reg_sel_e         lo_sel,
  output reg_sel_e         hi_sel,
  output logic             word_data,
  output logic             byte_data
);
  function automatic reg_sel_e sel_at(input logic tf, input logic ctl,
                                      input logic [OFF_W-1:0] o);
    if (tf)  return tf_sel(o);
    if (ctl) return ctl_sel(o);
    return RS_NONE;
  endfunction

  logic [OFF_W-1:0] even_off, odd_off;
  logic             data_off;

  assign even_off = {off[OFF_W-1:1], 1'b0};
  assign odd_off  = {off[OFF_W-1:1], 1'b1};
  assign data_off = in_tf && (off[OFF_W-1:1] == '0);

  always_comb begin
    lo_sel    = RS_NONE;
    hi_sel    = RS_NONE;
    word_data = 1'b0;
    byte_data = 1'b0;
    case (ce_mode)
      CE_WORD: begin
        if (data_off) word_data = 1'b1;
        else begin
          lo_sel = sel_at(in_tf, in_ctl, even_off);
          hi_sel = sel_at(in_tf, in_ctl, odd_off);
        end
      end
      CE_EVEN: begin
        if (in_tf && off == '0) byte_data = 1'b1;
        else lo_sel = sel_at(in_tf, in_ctl, off);
      end
      CE_ODD:  hi_sel = sel_at(in_tf, in_ctl, odd_off);
      default: ;
    endcase
  end

endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
  import ata_tf_pkg::*;
#(
  parameter int NREG = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lo_we,
  input  reg_sel_e                 lo_sel,
  input  logic [BYTE_W-1:0]        lo_byte,
  input  logic                     hi_we,
  input  reg_sel_e                 hi_sel,
  input  logic [BYTE_W-1:0]        hi_byte,
  output logic [NREG*BYTE_W-1:0]   regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam reg_sel_e MY_SEL = store_sel(g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (lo_we && lo_sel == MY_SEL)  q <= lo_byte;
      else if (hi_we && hi_sel == MY_SEL)  q <= hi_byte;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_we || hi_we) |=> $stable(regs_flat)); // R2

endmodule

// File: rtl/ata_tf_data_pair.sv
module ata_tf_data_pair
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_acc,
  input  logic              byte_wr,
  input  logic              word_acc,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] din_lo,
  output logic              odd_next,
  output logic [BYTE_W-1:0] even_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_next <= 1'b0;
      even_q   <= '0;
    end else if (word_acc || cmd_wr) begin
      odd_next <= 1'b0;
    end else if (byte_acc) begin
      odd_next <= ~odd_next;
      if (byte_wr && !odd_next) even_q <= din_lo;
    end
  end

  AST_PAIR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !word_acc && !cmd_wr) |=> (odd_next != $past(odd_next))); // R4

  AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_acc || cmd_wr) |=> !odd_next); // R3

endmodule

// File: rtl/ata_tf_decoder.sv
module ata_tf_decoder
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NPARAM = 6,
  localparam int NREG   = NPARAM + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sec_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ce1_n,
  input  logic                     ce2_n,
  input  logic                     iord_n,
  input  logic                     iowr_n,
  input  logic [WORD_W-1:0]        din,
  output logic [WORD_W-1:0]        dout,
  output logic                     doe,
  input  logic [BYTE_W-1:0]        status_in,
  input  logic [BYTE_W-1:0]        altstat_in,
  input  logic [BYTE_W-1:0]        error_in,
  input  logic [BYTE_W-1:0]        drvaddr_in,
  output logic                     cmd_valid,
  output logic [BYTE_W-1:0]        cmd_byte,
  output logic                     int_ack,
  output logic [BYTE_W-1:0]        devctl_out,
  output logic [NPARAM*BYTE_W-1:0] param_out,
  input  logic [WORD_W-1:0]        dp_rdata,
  output logic                     dp_rd,
  output logic                     dp_wr,
  output logic [WORD_W-1:0]        dp_wdata
);
  localparam int OFF_W = 3;

  // Named internal events
  logic             in_tf, in_ctl;
  logic [OFF_W-1:0] off;
  ce_mode_e         ce_mode;
  reg_sel_e         lo_sel, hi_sel;
  logic             word_data, byte_data;
  logic             rd_cyc, wr_cyc, acc_cyc;
  logic             pair_odd;
  logic [BYTE_W-1:0] even_q;
  logic [NREG*BYTE_W-1:0] regs_flat;
  logic [BYTE_W-1:0] lo_val, hi_val;
  logic [RD_SLOTS-1:0][BYTE_W-1:0] rd_bank;
  logic             ctl7_write;

  assign rd_cyc  = !iord_n && iowr_n;
  assign wr_cyc  = iord_n && !iowr_n;
  assign acc_cyc = rd_cyc || wr_cyc;
  assign ce_mode = ce_decode(ce1_n, ce2_n);

  ata_tf_addr_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr_dec (
    .clk(clk), .rst_n(rst_n), .sec_sel(sec_sel), .addr(addr),
    .in_tf(in_tf), .in_ctl(in_ctl), .off(off));

  ata_tf_lane_map #(.OFF_W(OFF_W)) i_lane_map (
    .ce_mode(ce_mode), .in_tf(in_tf), .in_ctl(in_ctl), .off(off),
    .lo_sel(lo_sel), .hi_sel(hi_sel),
    .word_data(word_data), .byte_data(byte_data));

  ata_tf_regfile #(.NREG(NREG)) i_regfile (
    .clk(clk), .rst_n(rst_n),
    .lo_we(wr_cyc && lo_sel != RS_NONE), .lo_sel(lo_sel), .lo_byte(din[BYTE_W-1:0]),
    .hi_we(wr_cyc && hi_sel != RS_NONE), .hi_sel(hi_sel), .hi_byte(din[WORD_W-1:BYTE_W]),
    .regs_flat(regs_flat));

  ata_tf_data_pair i_data_pair (
    .clk(clk), .rst_n(rst_n),
    .byte_acc(acc_cyc && byte_data), .byte_wr(wr_cyc),
    .word_acc(acc_cyc && word_data), .cmd_wr(cmd_valid),
    .din_lo(din[BYTE_W-1:0]),
    .odd_next(pair_odd), .even_q(even_q));

  assign param_out  = regs_flat[NPARAM*BYTE_W-1:0];
  assign devctl_out = regs_flat[NREG*BYTE_W-1:NPARAM*BYTE_W];

  // Read bank, in slot order of the package
  assign rd_bank = {drvaddr_in, altstat_in, status_in,
                    regs_flat[5*BYTE_W +: BYTE_W], regs_flat[4*BYTE_W +: BYTE_W],
                    regs_flat[3*BYTE_W +: BYTE_W], regs_flat[2*BYTE_W +: BYTE_W],
                    regs_flat[1*BYTE_W +: BYTE_W], error_in};
  assign lo_val  = bank_pick(lo_sel, rd_bank);
  assign hi_val  = bank_pick(hi_sel, rd_bank);

  always_comb begin
    doe  = 1'b0;
    dout = '0;
    if (rd_cyc) begin
      doe = word_data || byte_data || lo_sel != RS_NONE || hi_sel != RS_NONE;
      if (word_data)      dout = dp_rdata;
      else if (byte_data) dout = {{BYTE_W{1'b0}},
                                  pair_odd ? dp_rdata[WORD_W-1:BYTE_W] : dp_rdata[BYTE_W-1:0]};
      else                dout = {hi_val, lo_val};
    end
  end

  assign int_ack   = rd_cyc && (lo_sel == RS_STATCMD || hi_sel == RS_STATCMD);
  assign cmd_valid = wr_cyc && (lo_sel == RS_STATCMD || hi_sel == RS_STATCMD);
  assign cmd_byte  = (lo_sel == RS_STATCMD) ? din[BYTE_W-1:0] : din[WORD_W-1:BYTE_W];

  assign dp_rd    = rd_cyc && (word_data || (byte_data && pair_odd));
  assign dp_wr    = wr_cyc && (word_data || (byte_data && pair_odd));
  assign dp_wdata = word_data ? din : {din[BYTE_W-1:0], even_q};

  assign ctl7_write = wr_cyc && in_ctl && off == 3'd7 && ce_mode == CE_EVEN;

  AST_DOE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!iord_n && iowr_n)); // R10
  AST_INTACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> doe); // R6
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_rd && dp_wr)); // R3
  AST_CMD_CLEARS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !pair_odd); // R6
  AST_CTL7_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl7_write |=> $stable(devctl_out)); // R7
  AST_NO_STROBE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_tf && !in_ctl) |-> !(doe || cmd_valid || dp_rd || dp_wr || int_ack)); // R1

endmodule

// File: tb/test_ata_tf_decoder.sv
module test_ata_tf_decoder;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, sec_sel = 0;
  logic [9:0]  addr = '0;
  logic ce1_n = 1, ce2_n = 1, iord_n = 1, iowr_n = 1;
  logic [15:0] din = '0, dout, dp_rdata = 16'h1234, dp_wdata;
  logic doe, cmd_valid, int_ack, dp_rd, dp_wr;
  logic [7:0] status_in = 0, altstat_in = 0, error_in = 0, drvaddr_in = 0, cmd_byte, devctl_out;
  logic [47:0] param_out;

  ata_tf_decoder i_ata_tf_decoder (.*);

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Reference model state
  logic [7:0] m_reg [1:6];
  logic [7:0] m_devctl, m_even;
  bit m_odd;
  logic [7:0] n_reg [1:6];
  logic [7:0] n_devctl, n_even;
  bit n_odd;
  // Expected outputs
  logic [15:0] e_dout, e_wdata;
  bit e_doe, e_cmd, e_ack, e_rd, e_wr;
  logic [7:0] e_cmdb;
  string tag;

  task automatic model_reset();
    for (int i = 1; i <= 6; i++) m_reg[i] = 0;
    m_devctl = 0; m_even = 0; m_odd = 0;
  endtask

  task automatic model_byte(input int lane, input bit ctl, input int o, input bit rd, input bit wr);
    logic [7:0] b = lane ? din[15:8] : din[7:0];
    logic [7:0] v = 0;
    bit ok = 0;
    if (!ctl) begin
      tag = (o == 7) ? "R6" : "R2";
      if (rd) begin
        ok = 1;
        if (o == 1) v = error_in;
        else if (o == 7) begin v = status_in; e_ack = 1; end
        else v = m_reg[o];
      end
      if (wr) begin
        if (o == 7) begin e_cmd = 1; e_cmdb = b; n_odd = 0; end
        else n_reg[o] = b;
      end
    end else begin
      tag = "R7";
      if (rd) begin ok = 1; v = (o == 6) ? altstat_in : drvaddr_in; end
      if (wr && o == 6) n_devctl = b;
    end
    if (ok) begin
      e_doe = 1;
      if (lane) e_dout[15:8] = v; else e_dout[7:0] = v;
    end
  endtask

  task automatic model_eval();
    bit rd, wr, is_tf, is_ct, is_cu;
    int tfb, ctb, a, o;
    e_dout = 0; e_wdata = 0; e_doe = 0; e_cmd = 0; e_ack = 0; e_rd = 0; e_wr = 0; e_cmdb = 0;
    for (int i = 1; i <= 6; i++) n_reg[i] = m_reg[i];
    n_devctl = m_devctl; n_even = m_even; n_odd = m_odd;
    rd = !iord_n && iowr_n;
    wr = !iowr_n && iord_n;
    tfb = sec_sel ? 'h170 : 'h1F0;
    ctb = sec_sel ? 'h376 : 'h3F6;
    a = int'(addr);
    is_tf = a >= tfb && a < tfb + 8;
    is_ct = a == ctb || a == ctb + 1;
    is_cu = a >= ctb - 6 && a < ctb;
    o = is_tf ? a - tfb : a - ctb + 6;
    tag = (rd || wr) ? (is_cu ? "R8" : "R1") : ((!iord_n && !iowr_n) ? "R10" : "R11");
    if ((rd || wr) && (is_tf || is_ct)) begin
      if (!ce1_n && !ce2_n) begin
        if (is_tf && o < 2) begin
          tag = "R3"; n_odd = 0;
          if (rd) begin e_doe = 1; e_dout = dp_rdata; e_rd = 1; end
          if (wr) begin e_wr = 1; e_wdata = din; end
        end else begin
          model_byte(0, is_ct, o & 6, rd, wr);
          model_byte(1, is_ct, o | 1, rd, wr);
          tag = "R9";
        end
      end else if (!ce1_n) begin
        if (is_tf && o == 0) begin
          tag = "R4";
          if (rd) begin
            e_doe = 1;
            e_dout = {8'h00, m_odd ? dp_rdata[15:8] : dp_rdata[7:0]};
            e_rd = m_odd;
          end
          if (wr) begin
            if (!m_odd) n_even = din[7:0];
            else begin e_wr = 1; e_wdata = {din[7:0], m_even}; end
          end
          n_odd = !m_odd;
        end else model_byte(0, is_ct, o, rd, wr);
      end else if (!ce2_n) begin
        model_byte(1, is_ct, o | 1, rd, wr);
        if (is_tf && o < 2) tag = "R5";
      end
    end
  endtask

  task automatic fail_line(input string what, input logic [47:0] act, input logic [47:0] exp);
    miscompares++;
    $display("FAIL %s %s at vector %0d: actual %h expected %h", tag, what, vectors, act, exp);
  endtask

  task automatic compare();
    logic [47:0] e_param = {m_reg[6], m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[1]};
    vectors++;
    if (dout !== e_dout)      fail_line("dout", 48'(dout), 48'(e_dout));
    if (doe !== e_doe)        fail_line("doe", 48'(doe), 48'(e_doe));
    if (cmd_valid !== e_cmd)  fail_line("cmd_valid", 48'(cmd_valid), 48'(e_cmd));
    if (e_cmd && cmd_byte !== e_cmdb) fail_line("cmd_byte", 48'(cmd_byte), 48'(e_cmdb));
    if (int_ack !== e_ack)    fail_line("int_ack", 48'(int_ack), 48'(e_ack));
    if (dp_rd !== e_rd)       fail_line("dp_rd", 48'(dp_rd), 48'(e_rd));
    if (dp_wr !== e_wr)       fail_line("dp_wr", 48'(dp_wr), 48'(e_wr));
    if (e_wr && dp_wdata !== e_wdata) fail_line("dp_wdata", 48'(dp_wdata), 48'(e_wdata));
    if (param_out !== e_param) fail_line("param_out", param_out, e_param);
    if (devctl_out !== m_devctl) fail_line("devctl_out", 48'(devctl_out), 48'(m_devctl));
  endtask

  // One bus cycle: ce = {ce2_n, ce1_n}, rw = {iowr_n, iord_n}
  task automatic apply(input logic [9:0] a, input logic [1:0] ce, input logic [1:0] rw,
                       input logic [15:0] d);
    @(negedge clk);
    addr = a; {ce2_n, ce1_n} = ce; {iowr_n, iord_n} = rw; din = d;
    status_in = 8'($urandom); altstat_in = 8'($urandom);
    error_in = 8'($urandom); drvaddr_in = 8'($urandom);
    #1;
    model_eval();
    compare();
    @(posedge clk);
    for (int i = 1; i <= 6; i++) m_reg[i] = n_reg[i];
    m_devctl = n_devctl; m_even = n_even; m_odd = n_odd;
    if (e_rd) dp_rdata = dp_rdata + 16'h1357;
  endtask

  task automatic rdb(input logic [9:0] a);                  apply(a, 2'b10, 2'b10, 16'h0);  endtask
  task automatic wrb(input logic [9:0] a, input logic [7:0] v); apply(a, 2'b10, 2'b01, {8'h5A, v}); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    apply(10'h1F0, 2'b11, 2'b11, 0);              // reset state, R2
    // R2 parameter writes and readback, primary block
    for (int k = 1; k <= 6; k++) wrb(10'h1F0 + 10'(k), 8'(8'h10 * k + 3));
    for (int k = 1; k <= 6; k++) rdb(10'h1F0 + 10'(k));
    // R1 secondary addresses while primary selected
    wrb(10'h172, 8'hEE); rdb(10'h172); rdb(10'h2F2);
    sec_sel = 1;
    wrb(10'h172, 8'h77); rdb(10'h172); rdb(10'h1F2);
    sec_sel = 0;
    // R3 word data
    apply(10'h1F0, 2'b00, 2'b10, 0); apply(10'h1F1, 2'b00, 2'b01, 16'hBEEF);
    // R4 byte pairs: read pair, write pair
    rdb(10'h1F0); rdb(10'h1F0); wrb(10'h1F0, 8'h11); wrb(10'h1F0, 8'h22);
    // R4 interrupted by word access (R3), odd-lane error (R5), command (R6)
    wrb(10'h1F0, 8'h33); apply(10'h1F0, 2'b00, 2'b10, 0); wrb(10'h1F0, 8'h44);
    apply(10'h1F0, 2'b01, 2'b10, 0); apply(10'h1F0, 2'b01, 2'b01, 16'hC300);
    wrb(10'h1F0, 8'h55); rdb(10'h1F1);
    wrb(10'h1F0, 8'h66); wrb(10'h1F7, 8'hEC); wrb(10'h1F0, 8'h67); wrb(10'h1F0, 8'h68);
    // R6 status vs R7 alternate status
    rdb(10'h1F7); rdb(10'h3F6);
    // R7 control
    wrb(10'h3F6, 8'h06); rdb(10'h3F7); wrb(10'h3F7, 8'hFF); rdb(10'h3F6);
    // R8 undecoded control offsets
    for (int k = 0; k < 6; k++) begin rdb(10'h3F0 + 10'(k)); wrb(10'h3F0 + 10'(k), 8'h99); end
    // R9 word access to register pairs
    apply(10'h1F2, 2'b00, 2'b01, 16'hA1B2); apply(10'h1F3, 2'b00, 2'b10, 0);
    apply(10'h1F6, 2'b00, 2'b10, 0); apply(10'h3F6, 2'b00, 2'b10, 0);
    // R10 both strobes, no card enable
    apply(10'h1F2, 2'b10, 2'b00, 16'h00FF); apply(10'h1F2, 2'b11, 2'b10, 0);
    // R11 random traffic
    for (int n = 0; n < 6000; n++) begin
      logic [9:0] a;
      logic [1:0] rw;
      int sel = $urandom % 6;
      int tfb = sec_sel ? 'h170 : 'h1F0;
      int ctb = sec_sel ? 'h370 : 'h3F0;
      if (n % 700 == 0) sec_sel = ~sec_sel;
      case (sel)
        0, 1: a = 10'(tfb + ($urandom % 8));
        2:    a = 10'(ctb + ($urandom % 8));
        3:    a = 10'(sec_sel ? 'h1F0 + ($urandom % 8) : 'h170 + ($urandom % 8));
        4:    a = 10'($urandom);
        default: a = 10'(tfb);
      endcase
      rw = ($urandom % 10 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'b10 : 2'b01);
      apply(a, 2'($urandom), rw, 16'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule